// File: doc/BRIEF.md
# Load Result Formatter

This block turns the raw bytes that storage returns for a fixed-point load into the 64-bit value written to the destination register. An access covers 1, 2, 4 or 8 bytes. The result can be zero-extended, sign-extended, or built from the accessed bytes in reverse order and then zero-extended. The caller supplies the raw data together with the access size and two flags. The formatted value leaves the block through a single registered pipeline stage.

Both the input and the output are valid/ready streams.

- An input beat is taken on a clock edge where `in_valid` and `in_ready` are both high.
- `in_ready` is high whenever the output register is empty, or when the consumer is draining it in that same cycle.
- A result shown with `out_valid` high stays unchanged until `out_ready` takes it. Back-pressure therefore stalls the producer without any loss or reordering.

In the text below, register bit 0 is the most significant bit. RT[56:63] corresponds to `out_data[7:0]`, and RT[0:7] corresponds to `out_data[63:56]`.

Top module: `ldfmt_top`

## Requirements
- R1: `in_size` gives the access width: 0 for 1 byte, 1 for 2 bytes, 2 for 4 bytes and 3 for 8 bytes. For an N-byte access the raw data sits in `in_data[8N-1:0]`. The first storage byte (byte 0) is `in_data[8N-1:8N-8]`.
- R2: With `in_sext`=0 and `in_brev`=0, the N accessed bytes appear unchanged in the low 8N bits of the result, and every higher bit is 0. For a byte this means RT[56:63] holds the byte and RT[0:55] are cleared. The same rule applies to a halfword in RT[48:63] and a word in RT[32:63].
- R3: With `in_sext`=1 and `in_brev`=0, an access of 1, 2 or 4 bytes fills every result bit above the loaded item with a copy of the item's bit 0, which is `in_data[8N-1]`.
- R4: An 8-byte access without reversal returns `in_data` unchanged, whatever the value of `in_sext`.
- R5: A reversed 2-byte access (`in_brev`=1, `in_size`=1) returns 48 zero bits, then data[8:15], then data[0:7]. That is, `out_data[15:0]` = {`in_data[7:0]`, `in_data[15:8]`}.
- R6: A reversed 4-byte access returns 32 zero bits followed by data[24:31], data[16:23], data[8:15] and data[0:7], in that order.
- R7: A reversed 8-byte access reverses all eight bytes. Data[56:63] (`in_data[7:0]`) becomes RT[0:7] (`out_data[63:56]`).
- R8: Reversal always takes priority over sign extension. With both flags set, the result is the reversed, zero-extended value. A reversed 1-byte access equals the plain zero-extended byte.
- R9: Bits of `in_data` above the accessed N bytes have no effect on the result.
- R10: `in_ready` equals `!out_valid || out_ready`. An accepted beat appears on `out_data` with `out_valid` high on the next clock edge.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds its value.
- R12: While `rst_n` is low at a clock edge, `out_valid` is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Formatter can take a beat |
| in_data | input | 64 | Raw storage bytes, right-justified |
| in_size | input | 2 | Access width code (R1) |
| in_sext | input | 1 | Sign-extend request |
| in_brev | input | 1 | Byte-reverse request |
| out_valid | output | 1 | Formatted result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 64 | Formatted register value |

## Verification
A formatted value is due exactly one clock edge after its input handshake. `in_ready` is combinational, so it is due within the cycle in which `out_ready` is driven.

The bench keeps a behavioural model of the single output slot. At every falling edge it compares `out_valid` and `out_data` with that model, and it compares `in_ready` shortly after driving new inputs. A stalled result is therefore checked again each cycle it is held.

A directed pass covers every size and flag combination, using data whose sign bits are set and data whose sign bits are clear, with junk in the unused bytes. A random pass then adds random stalls on both sides.

// File: rtl/ldfmt_pkg.sv
package ldfmt_pkg;

  typedef enum logic [1:0] {
    MODE_ZERO = 2'd0,
    MODE_SIGN = 2'd1,
    MODE_SWAP = 2'd2
  } fmt_mode_e;

  // Reversal wins over sign extension.
  function automatic fmt_mode_e pick_mode(input logic sext, input logic brev);
    if (brev)      return MODE_SWAP;
    else if (sext) return MODE_SIGN;
    else           return MODE_ZERO;
  endfunction

endpackage

// File: rtl/ldfmt_swap.sv
module ldfmt_swap #(
  parameter int unsigned DATA_BYTES = 8,
  localparam int unsigned DW     = 8 * DATA_BYTES,
  localparam int unsigned NSIZES = $clog2(DATA_BYTES) + 1,
  localparam int unsigned SIZE_W = $clog2(NSIZES)
) (
  input  logic [DW-1:0]     data_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic [DW-1:0]     swap_o
);

  logic [DW-1:0] cand [NSIZES];

  for (genvar k = 0; k < NSIZES; k++) begin : g_size
    localparam int unsigned NB = 1 << k;
    logic [8*NB-1:0] rev;
    for (genvar b = 0; b < NB; b++) begin : g_byte
      assign rev[8*b +: 8] = data_i[8*(NB-1-b) +: 8];
    end
    if (NB < DATA_BYTES) begin : g_pad
      assign cand[k] = {{(DW-8*NB){1'b0}}, rev};
    end else begin : g_full
      assign cand[k] = rev;
    end
  end

  always_comb begin
    swap_o = '0;
    for (int k = 0; k < NSIZES; k++) begin
      if (int'(size_i) == k) swap_o = cand[k];
    end
  end

endmodule

// File: rtl/ldfmt_extend.sv
module ldfmt_extend #(
  parameter int unsigned DATA_BYTES = 8,
  localparam int unsigned DW     = 8 * DATA_BYTES,
  localparam int unsigned NSIZES = $clog2(DATA_BYTES) + 1,
  localparam int unsigned SIZE_W = $clog2(NSIZES)
) (
  input  logic [DW-1:0]     data_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              signed_i,
  output logic [DW-1:0]     ext_o
);

  logic [DW-1:0] cand [NSIZES];

  for (genvar k = 0; k < NSIZES; k++) begin : g_size
    localparam int unsigned NB = 1 << k;
    logic [8*NB-1:0] low;
    logic            fill;
    assign low  = data_i[8*NB-1:0];
    assign fill = signed_i & low[8*NB-1];
    if (NB < DATA_BYTES) begin : g_pad
      assign cand[k] = {{(DW-8*NB){fill}}, low};
    end else begin : g_full
      assign cand[k] = low;
    end
  end

  always_comb begin
    ext_o = '0;
    for (int k = 0; k < NSIZES; k++) begin
      if (int'(size_i) == k) ext_o = cand[k];
    end
  end

endmodule

// File: rtl/ldfmt_stage.sv
module ldfmt_stage #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [W-1:0] s_data,
  output logic         m_valid,
  input  logic         m_ready,
  output logic [W-1:0] m_data
);

  logic         full_q;
  logic [W-1:0] data_q;

  assign s_ready = !full_q || m_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
    end else if (s_valid && s_ready) begin
      full_q <= 1'b1;
    end else if (m_ready) begin
      full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (s_valid && s_ready) data_q <= s_data;
  end

  assign m_valid = full_q;
  assign m_data  = data_q;

endmodule

// File: rtl/ldfmt_top.sv
module ldfmt_top
  import ldfmt_pkg::*;
#(
  parameter int unsigned DATA_BYTES = 8,
  localparam int unsigned DW     = 8 * DATA_BYTES,
  localparam int unsigned NSIZES = $clog2(DATA_BYTES) + 1,
  localparam int unsigned SIZE_W = $clog2(NSIZES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DW-1:0]     in_data,
  input  logic [SIZE_W-1:0] in_size,
  input  logic              in_sext,
  input  logic              in_brev,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DW-1:0]     out_data
);

  fmt_mode_e     mode;
  logic [DW-1:0] swapped;
  logic [DW-1:0] extended;
  logic [DW-1:0] formatted;

  assign mode = pick_mode(in_sext, in_brev);

  ldfmt_swap #(.DATA_BYTES(DATA_BYTES)) u_swap (
    .data_i (in_data),
    .size_i (in_size),
    .swap_o (swapped)
  );

  ldfmt_extend #(.DATA_BYTES(DATA_BYTES)) u_ext (
    .data_i   (in_data),
    .size_i   (in_size),
    .signed_i (mode == MODE_SIGN),
    .ext_o    (extended)
  );

  assign formatted = (mode == MODE_SWAP) ? swapped : extended;

  ldfmt_stage #(.W(DW)) u_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_valid (in_valid),
    .s_ready (in_ready),
    .s_data  (formatted),
    .m_valid (out_valid),
    .m_ready (out_ready),
    .m_data  (out_data)
  );

endmodule

// File: rtl/ldfmt_checker.sv
module ldfmt_checker #(
  parameter int unsigned DATA_BYTES = 8,
  localparam int unsigned DW     = 8 * DATA_BYTES,
  localparam int unsigned NSIZES = $clog2(DATA_BYTES) + 1,
  localparam int unsigned SIZE_W = $clog2(NSIZES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DW-1:0]     in_data,
  input logic [SIZE_W-1:0] in_size,
  input logic              in_sext,
  input logic              in_brev,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DW-1:0]     out_data
);

  logic [SIZE_W-1:0] cap_size;
  logic              cap_signed;
  logic [DW-1:0]     hi_mask;
  logic              top_bit;
  logic              upper_clear;
  logic              upper_fill;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_size   <= '0;
      cap_signed <= 1'b0;
    end else if (in_valid && in_ready) begin
      cap_size   <= in_size;
      cap_signed <= in_sext && !in_brev;
    end
  end

  always_comb begin
    hi_mask = '0;
    top_bit = 1'b0;
    for (int b = 0; b < DATA_BYTES; b++) begin
      if (b >= (1 << cap_size)) hi_mask[8*b +: 8] = 8'hFF;
      if (b == (1 << cap_size) - 1) top_bit = out_data[8*b+7];
    end
  end

  assign upper_clear = (out_data & hi_mask) == '0;
  assign upper_fill  = top_bit ? ((out_data & hi_mask) == hi_mask) : upper_clear;

  p_ready_when_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  p_accept_shows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  p_hold_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_zero_upper_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !cap_signed) |-> upper_clear);

  p_sign_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cap_signed) |-> upper_fill);

endmodule

bind ldfmt_top ldfmt_checker #(.DATA_BYTES(DATA_BYTES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_data   (in_data),
  .in_size   (in_size),
  .in_sext   (in_sext),
  .in_brev   (in_brev),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/tb_ldfmt_top.sv
module tb_ldfmt_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_data = '0;
  logic [1:0]  in_size = '0;
  logic        in_sext = 1'b0;
  logic        in_brev = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [63:0] out_data;

  int    errors = 0;
  int    checks = 0;
  int    cycles = 0;
  bit    exp_valid = 1'b0;
  logic [63:0] exp_data = '0;
  string exp_tag = "";

  always #10 clk = ~clk;

  ldfmt_top dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_size(in_size), .in_sext(in_sext), .in_brev(in_brev),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [63:0] ref_fmt(logic [63:0] d, int sz, bit sx, bit br);
    int n = 1 << sz;
    logic [63:0] r = '0;
    if (br) begin
      for (int i = 0; i < n; i++) r[8*i +: 8] = d[8*(n-1-i) +: 8];
    end else begin
      for (int i = 0; i < n; i++) r[8*i +: 8] = d[8*i +: 8];
      if (sx && d[8*n-1]) begin
        for (int i = 8*n; i < 64; i++) r[i] = 1'b1;
      end
    end
    return r;
  endfunction

  function automatic string tag_of(int sz, bit sx, bit br);
    if (br && (sx || sz == 0)) return "R8";
    if (br && sz == 1) return "R5";
    if (br && sz == 2) return "R6";
    if (br) return "R7";
    if (sz == 3) return "R4";
    if (sx) return "R3";
    return "R2";
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(bit v, logic [63:0] d, int sz, bit sx, bit br, bit rdy);
    bit exp_rdy;
    // outputs reflect the previous edge; compare them here
    check(out_valid == exp_valid, "R10 R11 R12 valid", 64'(out_valid), 64'(exp_valid));
    if (exp_valid)
      check(out_data == exp_data, {"R1 R9 ", exp_tag}, out_data, exp_data);
    in_valid  = v;
    in_data   = d;
    in_size   = 2'(sz);
    in_sext   = sx;
    in_brev   = br;
    out_ready = rdy;
    #1;
    exp_rdy = !exp_valid || rdy;
    check(in_ready == exp_rdy, "R10 ready", 64'(in_ready), 64'(exp_rdy));
    if (v && exp_rdy) begin
      exp_data  = ref_fmt(d, sz, sx, br);
      exp_tag   = tag_of(sz, sx, br);
      exp_valid = 1'b1;
    end else if (rdy) begin
      exp_valid = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<100000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    logic [63:0] pats [2];
    pats[0] = 64'hF0E1_D2C3_B4A5_9687; // sign bits set at every size
    pats[1] = 64'h8F7E_6D5C_4B3A_2918; // sign bits clear below 8 bytes
    repeat (3) @(negedge clk);
    // R12: reset clears the output slot
    check(out_valid == 1'b0, "R12 reset", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // directed: every size and flag combination, both sign polarities
    for (int p = 0; p < 2; p++)
      for (int sz = 0; sz < 4; sz++)
        for (int f = 0; f < 4; f++)
          step(1'b1, pats[p], sz, f[0], f[1], 1'b1);
    step(1'b0, '0, 0, 1'b0, 1'b0, 1'b1);
    // directed stall: hold a result for several cycles (R11)
    step(1'b1, 64'h1122_3344_5566_7788, 3, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 4; i++) step(1'b1, 64'hDEAD_BEEF_0000_FFFF, 2, 1'b1, 1'b0, 1'b0);
    step(1'b0, '0, 0, 1'b0, 1'b0, 1'b1);
    // random traffic with back-pressure on both sides
    for (int i = 0; i < 4000; i++) begin
      logic [63:0] d = {$urandom(), $urandom()};
      step(($urandom % 4) != 0, d, int'($urandom % 4), 1'($urandom), 1'($urandom),
           ($urandom % 3) != 0);
    end
    step(1'b0, '0, 0, 1'b0, 1'b0, 1'b1);
    step(1'b0, '0, 0, 1'b0, 1'b0, 1'b1);
    finish_run();
  end

endmodule